// File: doc/BRIEF.md
# Source-Select Programmable Clock Divider

This block divides one of up to four reference sources down to a slower clock for a single clock domain. Each reference is presented to the block as a one-cycle enable pulse, a tick, in the block's own clock `clk_i`. A select input picks which reference drives the divider. A ratio field chooses the divide ratio through a stepped encoding: the ratio is the field plus one, multiplied by a fixed step. A zero field can be mapped instead to a separate fixed override ratio. The output `clk_o` is a registered level that changes only on ticks of the selected source.

Alongside the divided clock, the block reports the nominal output frequency as the selected source's nominal rate, integer-divided by the ratio currently applied. Software can compare this figure against the rate it expects. Selecting a source that does not exist parks the divider, with a low output and a reported rate of zero.

Changes to the select or the ratio field are not applied straight away. They are captured at the next output period boundary, and the divider then restarts from count zero, so no output period is ever cut short or stretched by a reconfiguration.

Top module: `srcsel_clk_div`

## Requirements
- R1: With a non-zero field F, one output period spans exactly (F+1)*STEP ticks of the selected source, measured from one rising edge of `clk_o` to the next.
- R2: A zero field gives a ratio of ZERO_RATIO when that parameter is non-zero. When ZERO_RATIO is zero, a zero field gives a ratio of STEP.
- R3: For a ratio R, `clk_o` stays high for floor(R/2) selected ticks and low for the remaining ticks, so odd ratios have a high phase one tick shorter than the low phase. With R equal to 1, each selected tick produces a high pulse of one `clk_o` cycle.
- R4: A change of `ratio_i` during a period has no effect on that period. It takes effect from the next period boundary onward.
- R5: A change of `sel_i` during a period takes effect only at the next boundary. Until that boundary, ticks of every other source leave `clk_o` and `rate_o` unchanged.
- R6: A select value of NUM_SRC or above is applied at the next boundary. From then on, `clk_o` stays low and `rate_o` reads 0, whatever ticks arrive.
- R7: `rate_o` equals SRC_RATE[sel] integer-divided by the applied ratio, where entry 0 of SRC_RATE is the least significant RATE_W bits. It is updated in the cycle after a new configuration is applied.
- R8: While `rst_ni` is low, `clk_o` is 0 and `rate_o` is 0.
- R9: After reset, or from the parked state, a valid select is applied on the next clock edge without waiting for a tick. The first selected tick after that raises `clk_o` and starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all ticks are synchronous to it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | NUM_SRC | One enable pulse per reference edge, one bit per source |
| sel_i | input | SEL_W | Requested source index |
| ratio_i | input | DIV_W | Requested ratio field in stepped encoding |
| clk_o | output | 1 | Divided clock level |
| rate_o | output | RATE_W | Nominal output rate of the applied configuration |

## Verification
The critical overlap is a reconfiguration arriving in the same cycle as the selected tick that closes a period. In that case the boundary must capture the new select and ratio, restart the count and raise `clk_o`, all in one edge. The bench provokes this in two ways. Directed runs rewrite the field or the select right after a rising edge, and randomized runs reconfigure while ticks of all sources arrive at random. It judges the result by counting selected ticks between successive edges of `clk_o`: the period in progress must keep the old ratio, and the next one must use the new ratio and report the matching `rate_o`.

// File: rtl/srcsel_clk_div_pkg.sv
package srcsel_clk_div_pkg;

    localparam int unsigned MAX_SRC = 4;

    // Width needed to hold the largest ratio the encoding can produce.
    function automatic int unsigned ratio_bits(int unsigned div_w, int unsigned step,
                                               int unsigned zero_ratio);
        int unsigned top_ratio;
        top_ratio = (32'd1 << div_w) * step;
        if (zero_ratio > top_ratio) top_ratio = zero_ratio;
        return $clog2(top_ratio + 1);
    endfunction

endpackage

// File: rtl/srcsel_clk_div_ratio.sv
// Decodes the stepped ratio field into an absolute divide ratio.
module srcsel_clk_div_ratio #(
    parameter int unsigned DIV_W      = 5,
    parameter int unsigned STEP       = 2,
    parameter int unsigned ZERO_RATIO = 20,
    parameter int unsigned RATIO_W    = 7
) (
    input  logic [DIV_W-1:0]   field_i,
    output logic [RATIO_W-1:0] ratio_o
);

    logic [RATIO_W-1:0] stepped;

    assign stepped = (RATIO_W'(field_i) + RATIO_W'(1)) * RATIO_W'(STEP);

    generate
        if (ZERO_RATIO != 0) begin : g_override
            assign ratio_o = (field_i == '0) ? RATIO_W'(ZERO_RATIO) : stepped;
        end else begin : g_plain
            assign ratio_o = stepped;
        end
    endgenerate

endmodule

// File: rtl/srcsel_clk_div_rate.sv
// Nominal output rate of the applied configuration.
module srcsel_clk_div_rate
    import srcsel_clk_div_pkg::*;
#(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned RATIO_W = 7,
    parameter int unsigned RATE_W  = 32,
    parameter logic [MAX_SRC-1:0][RATE_W-1:0] SRC_RATE = '0
) (
    input  logic               run_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [RATE_W-1:0]  rate_o
);

    logic [1:0] idx;

    assign idx = 2'(sel_i);

    always_comb begin
        rate_o = '0;
        if (run_i && (ratio_i != '0) && (32'(sel_i) < NUM_SRC)) begin
            rate_o = SRC_RATE[idx] / RATE_W'(ratio_i);
        end
    end

endmodule

// File: rtl/srcsel_clk_div.sv
// Source-select programmable clock divider (top).
module srcsel_clk_div
    import srcsel_clk_div_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 3,
    parameter int unsigned SEL_W      = 2,
    parameter int unsigned DIV_W      = 5,
    parameter int unsigned STEP       = 2,
    parameter int unsigned ZERO_RATIO = 20,
    parameter int unsigned RATE_W     = 32,
    parameter logic [MAX_SRC-1:0][RATE_W-1:0] SRC_RATE =
        {32'd0, 32'd500_000_000, 32'd400_000_000, 32'd333_000_000}
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DIV_W-1:0]   ratio_i,
    output logic               clk_o,
    output logic [RATE_W-1:0]  rate_o
);

    localparam int unsigned RATIO_W = ratio_bits(DIV_W, STEP, ZERO_RATIO);
    localparam int unsigned NSEL    = 1 << SEL_W;

    typedef struct packed {
        logic               run;
        logic [SEL_W-1:0]   sel;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] cnt;
        logic               clk;
    } state_t;

    state_t             s_d, s_q;
    logic [RATIO_W-1:0] new_ratio;
    logic [NSEL-1:0]    tick_pad;
    logic               sel_ok;
    logic               sel_tick;
    logic               at_end;

    // Signals exposed to the bound checker
    logic               run_q;
    logic [SEL_W-1:0]   act_sel_q;
    logic [RATIO_W-1:0] act_ratio_q;
    logic [RATIO_W-1:0] cnt_q;

    // Pad the tick vector to the full select range; absent sources never tick.
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_pad
            if (g < NUM_SRC) begin : g_src
                assign tick_pad[g] = src_tick_i[g];
            end else begin : g_none
                assign tick_pad[g] = 1'b0;
            end
        end
    endgenerate

    srcsel_clk_div_ratio #(
        .DIV_W      (DIV_W),
        .STEP       (STEP),
        .ZERO_RATIO (ZERO_RATIO),
        .RATIO_W    (RATIO_W)
    ) u_ratio (
        .field_i (ratio_i),
        .ratio_o (new_ratio)
    );

    assign sel_ok   = (32'(sel_i) < NUM_SRC);
    assign sel_tick = s_q.run && tick_pad[s_q.sel];
    assign at_end   = (s_q.cnt == s_q.ratio - RATIO_W'(1));

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            // Parked: apply the request at once, first tick closes a period
            s_d.run   = sel_ok;
            s_d.sel   = sel_i;
            s_d.ratio = new_ratio;
            s_d.cnt   = new_ratio - RATIO_W'(1);
            s_d.clk   = 1'b0;
        end else if (sel_tick) begin
            if (at_end) begin
                // Period boundary: capture request, restart count, high phase
                s_d.run   = sel_ok;
                s_d.sel   = sel_i;
                s_d.ratio = new_ratio;
                s_d.cnt   = '0;
                s_d.clk   = sel_ok;
            end else begin
                s_d.cnt = s_q.cnt + RATIO_W'(1);
                s_d.clk = ((s_q.cnt + RATIO_W'(1)) < (s_q.ratio >> 1));
            end
        end else if (s_q.ratio == RATIO_W'(1)) begin
            s_d.clk = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    srcsel_clk_div_rate #(
        .NUM_SRC  (NUM_SRC),
        .SEL_W    (SEL_W),
        .RATIO_W  (RATIO_W),
        .RATE_W   (RATE_W),
        .SRC_RATE (SRC_RATE)
    ) u_rate (
        .run_i   (s_q.run),
        .sel_i   (s_q.sel),
        .ratio_i (s_q.ratio),
        .rate_o  (rate_o)
    );

    assign clk_o       = s_q.clk;
    assign run_q       = s_q.run;
    assign act_sel_q   = s_q.sel;
    assign act_ratio_q = s_q.ratio;
    assign cnt_q       = s_q.cnt;

endmodule

// File: rtl/srcsel_clk_div_chk.sv
module srcsel_clk_div_chk #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned RATIO_W = 7,
    parameter int unsigned RATE_W  = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sel_tick,
    input logic               clk_o,
    input logic [RATE_W-1:0]  rate_o,
    input logic               run_q,
    input logic [SEL_W-1:0]   act_sel_q,
    input logic [RATIO_W-1:0] act_ratio_q,
    input logic [RATIO_W-1:0] cnt_q
);

    assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q |-> (cnt_q < act_ratio_q));

    assert_hold_between_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !sel_tick && act_ratio_q != RATIO_W'(1)) |=> $stable(clk_o));

    assert_cfg_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !(sel_tick && cnt_q == act_ratio_q - RATIO_W'(1)))
        |=> ($stable(act_ratio_q) && $stable(act_sel_q)));

    assert_parked_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> (!clk_o && rate_o == '0));

    assert_rise_needs_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> $past(sel_tick));

endmodule

bind srcsel_clk_div srcsel_clk_div_chk #(
    .SEL_W   (SEL_W),
    .RATIO_W (RATIO_W),
    .RATE_W  (RATE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_tick    (sel_tick),
    .clk_o       (clk_o),
    .rate_o      (rate_o),
    .run_q       (run_q),
    .act_sel_q   (act_sel_q),
    .act_ratio_q (act_ratio_q),
    .cnt_q       (cnt_q)
);

// File: tb/sim_srcsel_clk_div.sv
`timescale 1ns/1ps
module sim_srcsel_clk_div;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  ticks = '0;
    logic [3:0]  mask  = 4'hF;
    logic [1:0]  sel0  = '0;
    logic [4:0]  fld0  = '0;
    logic [0:0]  sel1  = '0;
    logic [2:0]  fld1  = '0;
    logic        clk0, clk1;
    logic [31:0] rate0, rate1;

    // u0: 3 sources, 5-bit field, step 2, zero field -> 20
    srcsel_clk_div u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(ticks[2:0]),
        .sel_i(sel0), .ratio_i(fld0), .clk_o(clk0), .rate_o(rate0)
    );

    // u1: 2 sources, 3-bit field, step 1, no zero override
    srcsel_clk_div #(
        .NUM_SRC(2), .SEL_W(1), .DIV_W(3), .STEP(1), .ZERO_RATIO(0), .RATE_W(32),
        .SRC_RATE({32'd0, 32'd0, 32'd540_000_000, 32'd500_000_000})
    ) u1 (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(ticks[1:0]),
        .sel_i(sel1), .ratio_i(fld1), .clk_o(clk1), .rate_o(rate1)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Edge monitor: counts selected ticks, stamps rising/falling edges
    int   msel   [2] = '{0, 0};
    int   tcnt   [2] = '{0, 0};
    int   nrise  [2] = '{0, 0};
    int   rise_a [2] = '{0, 0};
    int   rise_b [2] = '{0, 0};
    int   fall_t [2] = '{0, 0};
    logic pclk   [2] = '{1'b0, 1'b0};

    always @(negedge clk) begin
        logic v;
        bit   tk;
        for (int i = 0; i < 2; i++) begin
            v  = (i == 0) ? clk0 : clk1;
            tk = (msel[i] < ((i == 0) ? 3 : 2)) && ticks[msel[i]];
            if (rst_n) begin
                if (v && !pclk[i]) begin
                    rise_a[i] = rise_b[i];
                    rise_b[i] = tcnt[i];
                    nrise[i]++;
                end
                if (!v && pclk[i]) fall_t[i] = tcnt[i];
                if (tk) tcnt[i]++;
            end
            pclk[i] = v;
        end
    end

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog (all requirements): cycles=%0d expected below %0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ratio(int inst, int f);
        if (inst == 0) return (f == 0) ? 20 : (f + 1) * 2;
        return f + 1;
    endfunction

    function automatic longint exp_rate(int inst, int s, int r);
        longint base;
        if (inst == 0) base = (s == 0) ? 333000000 : (s == 1) ? 400000000 : (s == 2) ? 500000000 : 0;
        else           base = (s == 0) ? 500000000 : (s == 1) ? 540000000 : 0;
        return base / r;
    endfunction

    // One clock cycle of random ticks on enabled sources, no back-to-back ticks
    task automatic cyc1();
        @(posedge clk); #1;
        for (int s = 0; s < 4; s++)
            ticks[s] = mask[s] && !ticks[s] && ($urandom % 2 == 1);
        @(negedge clk); #1;
    endtask

    task automatic wait_rise(int inst);
        int base = nrise[inst];
        int g = 0;
        while (nrise[inst] == base && g < 6000) begin cyc1(); g++; end
    endtask

    task automatic measure(int inst, int s, int f, string req);
        int base, g, r;
        if (inst == 0) begin sel0 = 2'(s); fld0 = 5'(f); end
        else           begin sel1 = 1'(s); fld1 = 3'(f); end
        msel[inst] = s;
        base = nrise[inst];
        g = 0;
        while (nrise[inst] < base + 2 && g < 8000) begin cyc1(); g++; end
        r = exp_ratio(inst, f);
        chk(g < 8000, req, "edges seen within bound", g, 8000);
        chk(rise_b[inst] - rise_a[inst] == r, req, "period in ticks", rise_b[inst] - rise_a[inst], r);
        chk(fall_t[inst] - rise_a[inst] == r / 2, "R3", "high phase in ticks",
            fall_t[inst] - rise_a[inst], r / 2);
        chk(((inst == 0) ? rate0 : rate1) == exp_rate(inst, s, r), "R7", "reported rate",
            (inst == 0) ? rate0 : rate1, exp_rate(inst, s, r));
    endtask

    initial begin
        int changed;
        logic v;
        void'($urandom(32'd4711));

        // R8: outputs during reset
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(clk0 == 1'b0 && clk1 == 1'b0, "R8", "clk_o in reset", clk0, 0);
        chk(rate0 == 0 && rate1 == 0, "R8", "rate_o in reset", rate0 + rate1, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1/R2/R3 directed ratios
        measure(0, 1, 1, "R1");
        measure(0, 0, 31, "R1");
        measure(0, 2, 0, "R2");
        measure(1, 0, 0, "R2");
        measure(1, 0, 2, "R3");
        measure(1, 1, 4, "R3");
        measure(1, 1, 7, "R3");

        // R4: ratio change mid-period keeps the running period
        measure(0, 1, 1, "R4");
        wait_rise(0);
        fld0 = 5'd2;
        wait_rise(0);
        chk(rise_b[0] - rise_a[0] == 4, "R4", "period after mid-period change", rise_b[0] - rise_a[0], 4);
        wait_rise(0);
        chk(rise_b[0] - rise_a[0] == 6, "R4", "following period", rise_b[0] - rise_a[0], 6);

        // R5: select change waits for boundary; other sources ignored
        measure(0, 0, 1, "R5");
        wait_rise(0);
        sel0 = 2'd2;
        mask = 4'b0100;
        v = clk0;
        changed = 0;
        for (int k = 0; k < 40; k++) begin
            cyc1();
            if (clk0 != v) changed++;
        end
        chk(changed == 0, "R5", "clk_o changes on foreign ticks", changed, 0);
        chk(rate0 == 333000000 / 4, "R5", "rate before boundary", rate0, 333000000 / 4);
        mask = 4'hF;
        measure(0, 2, 1, "R5");

        // R6: undefined select parks the divider
        sel0 = 2'd3;
        msel[0] = 3;
        repeat (80) cyc1();
        chk(rate0 == 0, "R6", "rate for undefined select", rate0, 0);
        changed = 0;
        for (int k = 0; k < 100; k++) begin
            cyc1();
            if (clk0) changed++;
        end
        chk(changed == 0, "R6", "high cycles while parked", changed, 0);

        // R9: leaving the parked state
        mask = 4'h0;
        sel0 = 2'd1;
        fld0 = 5'd0;
        msel[0] = 1;
        cyc1();
        chk(rate0 == 400000000 / 20, "R9", "rate applied without tick", rate0, 400000000 / 20);
        chk(clk0 == 1'b0, "R9", "clk_o before first tick", clk0, 0);
        @(posedge clk); #1 ticks = 4'b0010;
        @(negedge clk); #1;
        @(posedge clk); #1 ticks = 4'b0000;
        @(negedge clk); #1;
        chk(clk0 == 1'b1, "R9", "clk_o after first tick", clk0, 1);
        mask = 4'hF;
        measure(0, 1, 0, "R2");

        // Randomized configurations
        for (int k = 0; k < 20; k++) measure(0, $urandom % 3, $urandom % 32, "R1");
        for (int k = 0; k < 10; k++) measure(1, $urandom % 2, $urandom % 8, "R3");

        summary();
        $finish;
    end

endmodule